// File: doc/BRIEF.md
# Frequency and Period Measurement Counter

This block measures an incoming logic signal in one of two ways. In frequency mode it counts the rising edges of the chosen input while a gate is open. The gate lasts a whole number of 1 kHz ticks. In period mode it counts a reference tick across a chosen number of whole input periods. Two already-squared inputs are available: a high-range input and a low-range input. Period measurement is allowed only on the low-range input. Both inputs pass through a synchronizer before any edge is detected.

Software works in a fixed order. It writes the configuration (input, mode and gate code) in one operation and issues a start in a separate one. It then polls the done flag and reads the 20-bit result. The result saturates at all ones instead of wrapping, and a sticky overflow flag marks that case. The result and the flags stay as they are until the next start.

Top module: `ucnt_top`

## Requirements
- R1: After reset, busy, done and ovf are 0, result is 0, and the stored configuration selects the high-range input, frequency mode and gate code 0.
- R2: In frequency mode the gate opens at the first tick_1k after start and closes at the N-th tick_1k after that. The result is the number of rising edges of the selected input seen while the gate is open. An edge in the closing tick's cycle is counted; an edge in the opening tick's cycle is not.
- R3: The gate code sets N as follows: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 32. In frequency mode N is a count of ticks; in period mode it is a count of input periods.
- R4: cfg_src 0 selects hi_in and cfg_src 1 selects lo_in. Activity on the other input has no effect on the result.
- R5: In period mode (cfg_mode 1 with cfg_src 1), counting starts at the first rising edge of lo_in after start. The block counts ref_tick pulses until the N-th rising edge after that one, and a pulse in the cycle of the closing edge is counted.
- R6: A configuration write that asks for period mode on the high-range input (cfg_src 0, cfg_mode 1) is stored as frequency mode.
- R7: The count never wraps. At the maximum value, a further count leaves the result at all ones and sets ovf, and ovf stays set until the next start.
- R8: done rises and busy falls in the same cycle that the measurement ends. A start makes busy 1 and clears done, ovf and result one cycle later. Between the end of a measurement and the next start, the result and done do not change.
- R9: The configuration is captured at start. A configuration write during a measurement does not change that measurement and takes effect at the next start.
- R10: Only rising edges are counted, after the input passes through a two-flop synchronizer. An input held at a constant level gives a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | One-cycle 1 kHz gate tick |
| ref_tick | input | 1 | One-cycle reference tick counted in period mode |
| hi_in | input | 1 | High-range measured input (asynchronous) |
| lo_in | input | 1 | Low-range measured input (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 1 | Input select: 0 high-range, 1 low-range |
| cfg_mode | input | 1 | Mode: 0 frequency, 1 period |
| cfg_gate | input | 2 | Gate code: 0/1/2/3 gives 1/4/8/32 |
| start | input | 1 | Starts a measurement; restarts one that is running |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Last measurement finished |
| ovf | output | 1 | Count saturated during the last measurement |
| result | output | CNT_W | Measured count |

## Verification
The bench aims at the ends of the window. An off-by-one at the opening or closing tick or edge would show up as one count too many or too few, against counts that are exact because the input periods divide the window evenly. Period mode is also requested on the high-range input: a design that kept that request would measure a period there, or would hang waiting on the idle low-range input. A narrow copy of the block is driven into saturation, where a wrapping counter would read back a small value with ovf clear. A configuration write in the middle of a measurement, and a check that the result stays frozen after done, catch designs that read the live configuration or go on counting after the gate has closed.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

  localparam int UNIT_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_MEAS = 2'd2
  } ucnt_state_e;

  typedef struct packed {
    logic       src;   // 0 high-range, 1 low-range
    logic       mode;  // 0 frequency, 1 period
    logic [1:0] gate;  // window length code
  } ucnt_cfg_t;

  function automatic logic [UNIT_W-1:0] gate_units(input logic [1:0] code);
    case (code)
      2'd0:    gate_units = UNIT_W'(1);
      2'd1:    gate_units = UNIT_W'(4);
      2'd2:    gate_units = UNIT_W'(8);
      default: gate_units = UNIT_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/ucnt_sync.sv
module ucnt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  assign pipe_d[0] = din;

  genvar gi;
  generate
    for (gi = 1; gi <= STAGES; gi++) begin : g_stage
      assign pipe_d[gi] = pipe_q[gi-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R10: a synchronized rising edge lasts exactly one cycle
  a_r10_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/ucnt_accum.sv
module ucnt_accum #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] acc,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] acc_q, acc_n;
  logic             ovf_q, ovf_n;

  always_comb begin
    acc_n = acc_q;
    ovf_n = ovf_q;
    if (clr) begin
      acc_n = '0;
      ovf_n = 1'b0;
    end else if (en) begin
      if (acc_q == CNT_MAX) ovf_n = 1'b1;
      else                  acc_n = acc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= acc_n;
      ovf_q <= ovf_n;
    end
  end

  assign acc = acc_q;
  assign ovf = ovf_q;

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en && acc_q == CNT_MAX) |=> (acc_q == CNT_MAX && ovf_q));

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (acc_q >= $past(acc_q)));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0 && !ovf_q));

endmodule

// File: rtl/ucnt_seq.sv
module ucnt_seq
  import ucnt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  ucnt_cfg_t cfg_cur,
  input  logic      tick,
  input  logic      ref_tick,
  input  logic      rise_hi,
  input  logic      rise_lo,
  output logic      busy,
  output logic      done,
  output logic      clr,
  output logic      cnt_en
);

  ucnt_state_e       state_q, state_n;
  ucnt_cfg_t         act_q, act_n;
  logic [UNIT_W-1:0] units_q, units_n;
  logic              done_q, done_n;
  logic              rise_sel;
  logic              unit_evt;
  logic [UNIT_W-1:0] units_lim;

  assign rise_sel  = act_q.src ? rise_lo : rise_hi;
  assign unit_evt  = act_q.mode ? rise_sel : tick;
  assign units_lim = gate_units(act_q.gate);

  always_comb begin
    state_n = state_q;
    act_n   = act_q;
    units_n = units_q;
    done_n  = done_q;
    clr     = 1'b0;
    cnt_en  = 1'b0;
    if (start) begin
      clr     = 1'b1;
      act_n   = cfg_cur;
      units_n = '0;
      done_n  = 1'b0;
      state_n = ST_ARM;
    end else begin
      case (state_q)
        ST_ARM: begin
          if (unit_evt) begin
            state_n = ST_MEAS;
            units_n = '0;
          end
        end
        ST_MEAS: begin
          cnt_en = act_q.mode ? ref_tick : rise_sel;
          if (unit_evt) begin
            if (units_q + 1'b1 == units_lim) begin
              state_n = ST_IDLE;
              done_n  = 1'b1;
              units_n = '0;
            end else begin
              units_n = units_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      units_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      act_q   <= act_n;
      units_q <= units_n;
      done_q  <= done_n;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_hi_freq_only: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(act_q.mode && !act_q.src));

  a_r3_close_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !act_q.mode) |-> $past(tick));

  a_r3_units_bound: assert property (@(posedge clk) disable iff (!rst_n)
    units_q < units_lim);

endmodule

// File: rtl/ucnt_top.sv
module ucnt_top
  import ucnt_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1k,
  input  logic             ref_tick,
  input  logic             hi_in,
  input  logic             lo_in,
  input  logic             cfg_we,
  input  logic             cfg_src,
  input  logic             cfg_mode,
  input  logic [1:0]       cfg_gate,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             ovf,
  output logic [CNT_W-1:0] result
);

  localparam int N_IN = 2;

  ucnt_cfg_t cfg_q, cfg_n;
  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] rise_v;
  logic            clr, cnt_en;

  // R6: period mode is only kept for the low-range input
  always_comb begin
    cfg_n = cfg_q;
    if (cfg_we) begin
      cfg_n.src  = cfg_src;
      cfg_n.mode = cfg_mode & cfg_src;
      cfg_n.gate = cfg_gate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end

  assign raw_in = {lo_in, hi_in};

  genvar gi;
  generate
    for (gi = 0; gi < N_IN; gi++) begin : g_in
      ucnt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in[gi]),
        .rise (rise_v[gi])
      );
    end
  endgenerate

  ucnt_seq seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cfg_cur (cfg_q),
    .tick    (tick_1k),
    .ref_tick(ref_tick),
    .rise_hi (rise_v[0]),
    .rise_lo (rise_v[1]),
    .busy    (busy),
    .done    (done),
    .clr     (clr),
    .cnt_en  (cnt_en)
  );

  ucnt_accum #(.CNT_W(CNT_W)) acc_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .en   (cnt_en),
    .acc  (result),
    .ovf  (ovf)
  );

  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));

endmodule

// File: tb/ucnt_top_tb_top.sv
`timescale 1ns/1ps
module ucnt_top_tb_top;

  localparam int TICK_DIV = 50;
  localparam int W  = 20;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_1k, ref_tick, hi_in, lo_in;
  logic cfg_we, cfg_src, cfg_mode, start;
  logic [1:0] cfg_gate;
  logic busy, done, ovf;
  logic [W-1:0] result;
  logic s_busy, s_done, s_ovf;
  logic [SW-1:0] s_result;

  always #2 clk = ~clk;

  ucnt_top #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .ref_tick(ref_tick),
    .hi_in(hi_in), .lo_in(lo_in), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_mode(cfg_mode), .cfg_gate(cfg_gate), .start(start),
    .busy(busy), .done(done), .ovf(ovf), .result(result));

  ucnt_top #(.CNT_W(SW)) small_i (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .ref_tick(ref_tick),
    .hi_in(hi_in), .lo_in(lo_in), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_mode(cfg_mode), .cfg_gate(cfg_gate), .start(start),
    .busy(s_busy), .done(s_done), .ovf(s_ovf), .result(s_result));

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Stimulus generators
  int hi_half = 0, lo_half = 0, ref_div = 1;
  initial begin
    int tc = 0, hc = 0, lc = 0, rc = 0;
    tick_1k = 0; ref_tick = 0; hi_in = 0; lo_in = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % TICK_DIV;
      tick_1k = (tc == 0);
      rc = (rc + 1) % ref_div;
      ref_tick = (rc == 0);
      if (hi_half != 0) begin hc++; if (hc >= hi_half) begin hc = 0; hi_in = ~hi_in; end end
      if (lo_half != 0) begin lc++; if (lc >= lo_half) begin lc = 0; lo_in = ~lo_in; end end
    end
  end

  // Behavioural reference model
  int m_state;  // 0 idle, 1 waiting, 2 counting
  int m_src, m_mode, m_gate, a_src, a_mode, a_gate, m_units;
  longint m_acc;
  bit m_ovf, m_done;
  bit h_hist[3], l_hist[3];

  function automatic int units_of(input int g);
    case (g) 0: return 1; 1: return 4; 2: return 8; default: return 32; endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_src = 0; m_mode = 0; m_gate = 0;
      a_src = 0; a_mode = 0; a_gate = 0; m_units = 0;
      m_acc = 0; m_ovf = 0; m_done = 0;
      for (int i = 0; i < 3; i++) begin h_hist[i] = 0; l_hist[i] = 0; end
    end else begin
      bit rh, rl, rs, evt, en;
      rh = h_hist[1] && !h_hist[2];
      rl = l_hist[1] && !l_hist[2];
      h_hist[2] = h_hist[1]; h_hist[1] = h_hist[0]; h_hist[0] = hi_in;
      l_hist[2] = l_hist[1]; l_hist[1] = l_hist[0]; l_hist[0] = lo_in;
      rs  = a_src ? rl : rh;
      evt = a_mode ? rs : tick_1k;
      if (start) begin
        m_acc = 0; m_ovf = 0; m_done = 0; m_units = 0; m_state = 1;
        a_src = m_src; a_mode = m_mode; a_gate = m_gate;
      end else if (m_state == 1) begin
        if (evt) m_state = 2;
      end else if (m_state == 2) begin
        en = a_mode ? ref_tick : rs;
        if (en) begin
          if (m_acc == (64'd1 << W) - 1) m_ovf = 1; else m_acc++;
        end
        if (evt) begin
          m_units++;
          if (m_units == units_of(a_gate)) begin
            m_state = 0; m_done = 1; m_units = 0;
          end
        end
      end
      if (cfg_we) begin
        m_src = cfg_src; m_mode = cfg_mode && cfg_src; m_gate = cfg_gate;
      end
    end
  end

  // Lockstep comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (result != m_acc[W-1:0] || done != m_done || busy != (m_state != 0) || ovf != m_ovf) begin
        errors++;
        $display("FAIL R2/R5/R8 lockstep actual=%0d/%0b/%0b/%0b expected=%0d/%0b/%0b/%0b at %0t",
                 result, done, busy, ovf, m_acc, m_done, (m_state != 0), m_ovf, $time);
      end
    end
  end

  task automatic do_cfg(input bit s, input bit m, input bit [1:0] g);
    @(negedge clk); cfg_we = 1; cfg_src = s; cfg_mode = m; cfg_gate = g;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!(done && !busy) && n < 5000) begin @(negedge clk); n++; end
    check({tag, " done reached"}, done, 1);
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] held;
    rst_n = 0; cfg_we = 0; cfg_src = 0; cfg_mode = 0; cfg_gate = 0; start = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 result", result, 0);
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
    check("R1 ovf", ovf, 0);

    // R1 default config: high input, frequency, one tick (period 10 -> 5)
    hi_half = 5; lo_half = 0; settle();
    do_start(); wait_done("R1");
    check("R1 default freq hi gate1", result, 5);

    // R2 R3 gate code 3 on high input: 32 ticks * 50 / 10
    do_cfg(0, 0, 3); settle(); do_start(); wait_done("R3");
    check("R3 gate32 count", result, 160);

    // R3 gate code 2
    do_cfg(0, 0, 2); settle(); do_start(); wait_done("R3");
    check("R3 gate8 count", result, 40);

    // R4 low input selected, high input toggling fast
    hi_half = 2; lo_half = 10; settle();
    do_cfg(1, 0, 2); settle(); do_start(); wait_done("R4");
    check("R4 lo freq gate8", result, 20);

    // R5 period mode on low: 4 periods of 10, ref every cycle
    lo_half = 5; ref_div = 1; settle();
    do_cfg(1, 1, 1); settle(); do_start(); wait_done("R5");
    check("R5 period ref1", result, 40);
    ref_div = 2; settle(); do_start(); wait_done("R5");
    check("R5 period ref2", result, 20);
    ref_div = 1;

    // R6 period requested on high input behaves as frequency
    hi_half = 5; lo_half = 0; settle();
    do_cfg(0, 1, 1); settle(); do_start(); wait_done("R6");
    check("R6 hi period forced freq", result, 20);

    // R7 saturation on the narrow instance, exact on the wide one
    lo_half = 50; settle();
    do_cfg(1, 1, 0); settle(); do_start(); wait_done("R7");
    check("R7 wide count", result, 100);
    check("R7 wide ovf", ovf, 0);
    check("R7 narrow saturates", s_result, 63);
    check("R7 narrow ovf", s_ovf, 1);

    // R8 result and done hold after the measurement, start clears
    held = result;
    repeat (300) @(negedge clk);
    check("R8 result held", result, held);
    check("R8 done held", done, 1);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check("R8 start clears done", done, 0);
    check("R8 start clears result", result, 0);
    check("R8 start clears ovf", s_ovf, 0);
    check("R8 busy after start", busy, 1);
    wait_done("R8");

    // R9 config write during a measurement applies only to the next one
    hi_half = 5; lo_half = 5; settle();
    do_cfg(0, 0, 0); settle(); do_start();
    do_cfg(1, 1, 3);
    wait_done("R9");
    check("R9 running meas unchanged", result, 5);
    settle(); do_start(); wait_done("R9");
    check("R9 next meas uses new cfg", result, 320);

    // R10 a constant input level gives no counts
    hi_half = 0; lo_half = 0; settle();
    do_cfg(0, 0, 1); settle(); do_start(); wait_done("R10");
    check("R10 static input", result, 0);

    finish_run();
  end

endmodule